// File: doc/BRIEF.md
# Bus Master Throttle Timer

This block sits beside a bus-mastering engine and decides when that engine may ask for the shared system bus. When the engine signals that it needs the bus, the block raises a hold request and waits for a start event. Once the start event arrives, an on-time counter limits how long the request stays up. When that counter expires, the block drops the request and runs an off-time counter. Until the off-time ends, the request cannot come back.

A mode input picks the start event. In internal mode, the on-time counter starts when the grant (HLDA) is seen while the request is up. In external mode, it starts when a separate bus-request input (BREQ) is asserted. That input is typically tied to the bus-request output of the host processor. Both intervals are loaded from inputs and counted in clock cycles. A loaded value N gives an interval of N+1 cycles, so zero gives a single cycle. If the engine withdraws its need during the on-time, the request drops at once and no rest period follows.

Top module: `tt_bus_throttle`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, `hold` is low on the following cycle and both interval counters are cleared.
- R2: With the block idle and not resting, `bus_need` sampled high raises `hold` on the next clock.
- R3: With `ext_mode`=0, the on-time starts at the first clock edge where `hlda` is sampled high while `hold` is high. `hold` then stays high for exactly `ton_val`+1 further cycles and drops, provided `bus_need` stays high.
- R4: With `ext_mode`=1, the on-time starts at the first clock edge where `breq` is sampled high while `hold` is high, and `hlda` does not start it. With `ext_mode`=0, `breq` does not start it.
- R5: After an on-time expiry, `hold` stays low for exactly `toff_val`+1 cycles, even while `bus_need` remains high.
- R6: When the off-time expires and `bus_need` is high, `hold` is high on the next cycle.
- R7: When the off-time expires and `bus_need` is low, `hold` stays low until `bus_need` rises again.
- R8: If `bus_need` is sampled low during the on-time, `hold` is low on the next cycle and the on-time counter is cleared. No off-time follows, so a new `bus_need` raises `hold` one clock later.
- R9: A loaded value of zero gives an interval of one cycle for both timers, and a counter that reaches zero does not wrap.
- R10: While `hold` is high and no start event has been seen, `hold` stays high for as long as `bus_need` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_need | input | 1 | The engine wants the bus |
| hlda | input | 1 | Bus grant from the arbiter |
| breq | input | 1 | External start input for the on-time (external mode) |
| ext_mode | input | 1 | 0: grant starts the on-time, 1: `breq` starts it |
| ton_val | input | CNT_W | On-time value, interval is value+1 cycles |
| toff_val | input | CNT_W | Off-time value, interval is value+1 cycles |
| hold | output | 1 | Bus hold request |

## Verification
A corrupted phase state or counter shows up at `hold` alone. Three symptoms are possible: a high interval that is too long or too short, a rest period that is missing or the wrong length, or a request that never comes back. Each burst is timed edge by edge from the start event, so an off-by-one in either counter shows up within one interval of its start. Directed cases cover a withdrawal during the on-time, a rest that ends with no pending need, start events from the wrong source, and reset in mid-burst. Each of these shows at `hold` on the next cycle or within a rest period.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no request
        PH_WAIT = 2'd1,   // hold up, waiting for start event
        PH_ON   = 2'd2,   // on-time counting, hold up
        PH_REST = 2'd3    // off-time counting, hold forced low
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   hold;
    } ctl_t;

endpackage

// File: rtl/tt_interval_ctr.sv
module tt_interval_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.cnt = '0;
        end else if (load) begin
            ctr_d.cnt = load_val;
        end else if (dec && (ctr_q.cnt != '0)) begin
            ctr_d.cnt = ctr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign count   = ctr_q.cnt;
    assign expired = (ctr_q.cnt == '0);

    // a counter sitting at zero never wraps to all ones
    AST_CTR_NO_WRAP: assert property (@(posedge clk)
        (expired && !load && !clr) |=> expired); // R9

endmodule

// File: rtl/tt_start_sel.sv
module tt_start_sel (
    input  logic ext_mode,
    input  logic hold,
    input  logic hlda,
    input  logic breq,
    output logic start
);

    logic src;

    always_comb begin
        src   = ext_mode ? breq : hlda;
        start = hold & src;
    end

endmodule

// File: rtl/tt_bus_throttle.sv
module tt_bus_throttle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_need,
    input  logic             hlda,
    input  logic             breq,
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] ton_val,
    input  logic [CNT_W-1:0] toff_val,
    output logic             hold
);
    import tt_pkg::*;

    ctl_t ctl_d, ctl_q;

    logic             start;
    logic             on_clr, on_load, on_dec, on_expired;
    logic             off_clr, off_load, off_dec, off_expired;
    logic [CNT_W-1:0] on_count, off_count;

    tt_start_sel u_start (
        .ext_mode (ext_mode),
        .hold     (ctl_q.hold),
        .hlda     (hlda),
        .breq     (breq),
        .start    (start)
    );

    tt_interval_ctr #(.CNT_W(CNT_W)) u_on_ctr (
        .clk      (clk),
        .clr      (on_clr),
        .load     (on_load),
        .load_val (ton_val),
        .dec      (on_dec),
        .count    (on_count),
        .expired  (on_expired)
    );

    tt_interval_ctr #(.CNT_W(CNT_W)) u_off_ctr (
        .clk      (clk),
        .clr      (off_clr),
        .load     (off_load),
        .load_val (toff_val),
        .dec      (off_dec),
        .count    (off_count),
        .expired  (off_expired)
    );

    always_comb begin
        ctl_d    = ctl_q;
        on_clr   = 1'b0;
        on_load  = 1'b0;
        on_dec   = 1'b0;
        off_clr  = 1'b0;
        off_load = 1'b0;
        off_dec  = 1'b0;

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (bus_need) ctl_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (!bus_need) begin
                    ctl_d.ph = PH_IDLE;
                end else if (start) begin
                    ctl_d.ph = PH_ON;
                    on_load  = 1'b1;
                end
            end
            PH_ON: begin
                if (!bus_need) begin
                    ctl_d.ph = PH_IDLE;
                    on_clr   = 1'b1;
                end else if (on_expired) begin
                    ctl_d.ph = PH_REST;
                    off_load = 1'b1;
                end else begin
                    on_dec = 1'b1;
                end
            end
            PH_REST: begin
                if (off_expired) begin
                    ctl_d.ph = bus_need ? PH_WAIT : PH_IDLE;
                end else begin
                    off_dec = 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase

        ctl_d.hold = (ctl_d.ph == PH_WAIT) || (ctl_d.ph == PH_ON);

        if (rst) begin
            ctl_d.ph   = PH_IDLE;
            ctl_d.hold = 1'b0;
            on_clr     = 1'b1;
            off_clr    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign hold = ctl_q.hold;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!hold && on_expired && off_expired)); // R1

    AST_IDLE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_IDLE && bus_need) |=> hold); // R2

    AST_WAIT_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_WAIT && bus_need && !start) |=> hold); // R10

    AST_ON_LOADED: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_WAIT && bus_need && start) |=> (hold && on_count == $past(ton_val))); // R3

    AST_REST_LOADED: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_ON && bus_need && on_expired) |=> (!hold && off_count == $past(toff_val))); // R5

    AST_REST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_REST && !off_expired) |=> !hold); // R5

    AST_REST_REASSERT: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_REST && off_expired && bus_need) |=> hold); // R6

    AST_REST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_REST && off_expired && !bus_need) |=> !hold); // R7

    AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.ph == PH_ON && !bus_need) |=> (!hold && on_expired && off_expired)); // R8

endmodule

// File: tb/tt_bus_throttle_tb.sv
module tt_bus_throttle_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int NVEC       = 6;
    localparam int LIMIT      = 600;

    typedef struct packed {
        logic             ext;
        logic [CNT_W-1:0] ton;
        logic [CNT_W-1:0] toff;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd3, 8'd2},
        '{1'b0, 8'd0, 8'd0},
        '{1'b1, 8'd5, 8'd1},
        '{1'b1, 8'd0, 8'd4},
        '{1'b0, 8'd7, 8'd7},
        '{1'b1, 8'd2, 8'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_need = 1'b0;
    logic             hlda = 1'b0;
    logic             breq = 1'b0;
    logic             ext_mode = 1'b0;
    logic [CNT_W-1:0] ton_val = '0;
    logic [CNT_W-1:0] toff_val = '0;
    logic             hold;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_bus_throttle #(.CNT_W(CNT_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_need (bus_need),
        .hlda     (hlda),
        .breq     (breq),
        .ext_mode (ext_mode),
        .ton_val  (ton_val),
        .toff_val (toff_val),
        .hold     (hold)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_need = 1'b0; hlda = 1'b0; breq = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(hold == 1'b0, "R1 reset hold", int'(hold), 0);
        rst = 1'b0;
    endtask

    // count consecutive negedges with hold at level lvl, starting at the next negedge
    task automatic count_level(input logic lvl, output int n);
        n = 0;
        @(negedge clk);
        while (hold == lvl && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n_on, n_off;
        do_reset();
        ext_mode = v.ext; ton_val = v.ton; toff_val = v.toff;
        bus_need = 1'b1;
        @(negedge clk);
        check(hold == 1'b1, "R2 request", int'(hold), 1);
        if (v.ext) breq = 1'b1; else hlda = 1'b1;
        count_level(1'b1, n_on);
        check(n_on == int'(v.ton) + 1, v.ext ? "R4 ext on-time" : "R3 int on-time",
              n_on, int'(v.ton) + 1);
        hlda = 1'b0; breq = 1'b0;
        // first low negedge already reached: count it plus the rest
        n_off = 1;
        @(negedge clk);
        while (hold == 1'b0 && n_off < LIMIT) begin
            n_off++;
            @(negedge clk);
        end
        check(n_off == int'(v.toff) + 1, "R5 off-time", n_off, int'(v.toff) + 1);
        check(hold == 1'b1, "R6 reassert", int'(hold), 1);
        if (v.ton == 0 || v.toff == 0)
            check(n_on + n_off == int'(v.ton) + int'(v.toff) + 2, "R9 zero interval",
                  n_on + n_off, int'(v.ton) + int'(v.toff) + 2);
        bus_need = 1'b0;
    endtask

    initial begin
        int n;
        bit stayed;
        do_reset();

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10: no start event keeps hold high
        do_reset();
        ext_mode = 1'b0; ton_val = 8'd2; toff_val = 8'd2;
        bus_need = 1'b1;
        stayed = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!hold) stayed = 1'b0;
        end
        check(stayed, "R10 wait without start", int'(stayed), 1);

        // R4: external mode ignores hlda
        do_reset();
        ext_mode = 1'b1; ton_val = 8'd1; toff_val = 8'd1;
        bus_need = 1'b1; hlda = 1'b1;
        stayed = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!hold) stayed = 1'b0;
        end
        check(stayed, "R4 hlda ignored in ext mode", int'(stayed), 1);

        // R4: internal mode ignores breq
        do_reset();
        ext_mode = 1'b0; bus_need = 1'b1; breq = 1'b1;
        stayed = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!hold) stayed = 1'b0;
        end
        check(stayed, "R4 breq ignored in int mode", int'(stayed), 1);

        // R8: withdrawal during on-time, no rest period
        do_reset();
        ext_mode = 1'b0; ton_val = 8'd10; toff_val = 8'd10;
        bus_need = 1'b1;
        @(negedge clk);
        hlda = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_need = 1'b0; hlda = 1'b0;
        @(negedge clk);
        check(hold == 1'b0, "R8 drop at once", int'(hold), 0);
        bus_need = 1'b1;
        @(negedge clk);
        check(hold == 1'b1, "R8 no rest after abort", int'(hold), 1);
        // fresh on-time after abort runs its full length
        hlda = 1'b1;
        count_level(1'b1, n);
        check(n == 11, "R8 counter cleared", n, 11);

        // R7: rest ends with no need, hold stays low
        do_reset();
        ext_mode = 1'b1; ton_val = 8'd1; toff_val = 8'd3;
        bus_need = 1'b1;
        @(negedge clk);
        breq = 1'b1;
        count_level(1'b1, n);
        breq = 1'b0; bus_need = 1'b0;
        stayed = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (hold) stayed = 1'b0;
        end
        check(stayed, "R7 idle after rest", int'(stayed), 1);
        bus_need = 1'b1;
        @(negedge clk);
        check(hold == 1'b1, "R7 new need after idle", int'(hold), 1);

        // R1: reset in mid on-time
        do_reset();
        ext_mode = 1'b0; ton_val = 8'd20; toff_val = 8'd5;
        bus_need = 1'b1;
        @(negedge clk);
        hlda = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(hold == 1'b0, "R1 reset mid burst", int'(hold), 0);
        rst = 1'b0;
        @(negedge clk);
        check(hold == 1'b1, "R1 restart after reset", int'(hold), 1);
        count_level(1'b1, n);
        check(n == 21, "R1 on counter restarts", n, 21);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule